// File: doc/BRIEF.md
# GPIO Pad Pull and Drive Configuration Bank

This block holds the pad settings for one bank of general-purpose pins and turns them into the control lines that go to the pads. Software reaches it through a simple word-wide register port. Each access gives a byte offset, a write strobe and the write data. The read data is combinational from the offset.

For every pin the bank stores two pull settings: a pull-resistor enable and a direction bit that picks up or down. It also stores a drive-strength code. The code is bit-sliced: each of several consecutive word registers holds one bit of the code for every pin. The block decodes these into per-pin pull-up and pull-down enables and a per-pin strength code. It also gives a helper value with each pin's drive current in milliamps. Analog pad behaviour and pin multiplexing live elsewhere.

Top module: `padcfg_bank`

## Requirements
- R1: After reset every register reads zero, no pull is enabled on any pin, every strength code is 0 and every current value is 2 mA.
- R2: The pull-direction register is at byte offset 0x34. A write replaces the whole word and a read returns it. Bit n set to 1 selects pull-up for pin n, and 0 selects pull-down.
- R3: The resistor-enable register is at byte offset 0x38. A write replaces the whole word and a read returns it. Bit n enables the pull on pin n.
- R4: The strength registers are at byte offsets 0x58, 0x5C and 0x60. Register k (k = 0, 1, 2) holds bit k of pin n's code at bit position n. Each is written as a whole word and reads back its stored value.
- R5: Pin n's pull-up output is 1 exactly when its enable bit and its direction bit are both 1.
- R6: Pin n's pull-down output is 1 exactly when its enable bit is 1 and its direction bit is 0. Pull-up and pull-down are never both 1 on a pin.
- R7: When a pin's enable bit is 0, both of its pull outputs are 0 whatever its direction bit holds.
- R8: Pin n's strength output `drv_code[3n+2:3n]` equals {bit n of 0x60, bit n of 0x5C, bit n of 0x58}.
- R9: Pin n's current output `drv_ma[5n+4:5n]` equals (code + 1) * 2, covering 2 to 16 mA in 2 mA steps.
- R10: Any offset other than the five above, including misaligned ones, reads as zero. A write to such an offset changes no register and no output.
- R11: Register and output changes from a write are visible from the first clock edge at which the write strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pull_up_en | output | 32 | Per-pin pull-up enable |
| pull_dn_en | output | 32 | Per-pin pull-down enable |
| drv_code | output | 96 | Per-pin 3-bit strength code, pin n at [3n+2:3n] |
| drv_ma | output | 160 | Per-pin drive current in mA, pin n at [5n+4:5n] |

## Verification
A corrupted stored bit shows up at once in two places. It appears in the read data for its offset, and in the same cycle it appears on the matching pin's pull or strength output, because both come straight from the registers. A write that lands in the wrong register, or a bit that lands in the wrong lane, shows at the next falling edge after the write. The bench sees it there as a wrong pin or a wrong slice, since it checks every pin after every write. Writes with a wrong decode at unmapped offsets show up as changed read-back words in the check that follows the write.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned IDX_PDIR   = 0;
   localparam int unsigned IDX_PEN    = 1;
   localparam int unsigned IDX_DRV0   = 2;

   function automatic int unsigned code_to_ma(int unsigned code);
      return (code + 1) * 2;
   endfunction
endpackage

// File: rtl/padcfg_regfile.sv
module padcfg_regfile #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned NREG   = 5,
   parameter logic [NREG-1:0][ADDR_W-1:0] OFS = '0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   output logic [DATA_W-1:0]              rdata,
   output logic [NREG-1:0][DATA_W-1:0]    regs_q
);
   logic [NREG-1:0] hit;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      assign hit[g] = (addr == OFS[g]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[g] <= '0;
         else if (wr && hit[g])
            regs_q[g] <= wdata;
      end

      // R2 / R3 / R4 / R11: addressed write lands whole at the next edge
      p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && hit[g]) |=> (regs_q[g] == $past(wdata)));
      // R10: a register not addressed by a write keeps its value
      p_hold_unaddressed_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr && hit[g]) |=> $stable(regs_q[g]));
   end

   always_comb begin
      rdata = '0;
      for (int g = 0; g < NREG; g++)
         if (hit[g]) rdata = rdata | regs_q[g];
   end

   // R10: unmapped offsets read as zero
   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (rdata == '0));
endmodule

// File: rtl/padcfg_pin_decode.sv
module padcfg_pin_decode #(
   parameter int unsigned DRV_BITS = 3,
   localparam int unsigned MA_W    = DRV_BITS + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pen,
   input  logic                pdir,
   input  logic [DRV_BITS-1:0] drv_bits,
   output logic                up,
   output logic                dn,
   output logic [DRV_BITS-1:0] code,
   output logic [MA_W-1:0]     ma
);
   logic [MA_W-1:0] code_ext;

   assign up       = pen & pdir;
   assign dn       = pen & ~pdir;
   assign code     = drv_bits;
   assign code_ext = MA_W'(drv_bits);
   assign ma       = (code_ext + MA_W'(1)) << 1;

   // R6: never both pulls on one pin
   p_exclusive_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn));
   // R7: a disabled resistor drives neither pull
   p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pen |-> (!up && !dn));
   // R9: current is even and at least 2 mA
   p_ma_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ma[0] == 1'b0) && (ma >= MA_W'(2)));
endmodule

// File: rtl/padcfg_bank.sv
module padcfg_bank #(
   parameter int unsigned NPIN      = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DRV_BITS  = 3,
   parameter int unsigned PDIR_OFS  = 'h34,
   parameter int unsigned PEN_OFS   = 'h38,
   parameter int unsigned DRV_OFS   = 'h58,
   localparam int unsigned MA_W     = DRV_BITS + 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   output logic [NPIN-1:0]            pull_up_en,
   output logic [NPIN-1:0]            pull_dn_en,
   output logic [NPIN*DRV_BITS-1:0]   drv_code,
   output logic [NPIN*MA_W-1:0]       drv_ma
);
   import padcfg_pkg::*;

   localparam int unsigned NREG = IDX_DRV0 + DRV_BITS;

   function automatic logic [NREG-1:0][ADDR_W-1:0] build_ofs();
      logic [NREG-1:0][ADDR_W-1:0] o;
      o[IDX_PDIR] = ADDR_W'(PDIR_OFS);
      o[IDX_PEN]  = ADDR_W'(PEN_OFS);
      for (int k = 0; k < int'(DRV_BITS); k++)
         o[IDX_DRV0 + k] = ADDR_W'(DRV_OFS + WORD_BYTES * k);
      return o;
   endfunction

   localparam logic [NREG-1:0][ADDR_W-1:0] OFS = build_ofs();

   // elaboration checks
   if (NPIN > DATA_W) begin : g_err_npin
      $error("padcfg_bank: NPIN must not exceed DATA_W");
   end
   if (DRV_BITS < 1) begin : g_err_drv
      $error("padcfg_bank: DRV_BITS must be at least 1");
   end
   if (DRV_OFS + WORD_BYTES * DRV_BITS > (1 << ADDR_W)) begin : g_err_span
      $error("padcfg_bank: strength registers exceed the address space");
   end
   for (genvar g = 0; g < NREG; g++) begin : g_chk
      if (OFS[g][1:0] != 2'b00) begin : g_err_align
         $error("padcfg_bank: register offset not word aligned");
      end
      for (genvar h = g + 1; h < NREG; h++) begin : g_chk_pair
         if (OFS[g] == OFS[h]) begin : g_err_overlap
            $error("padcfg_bank: register offsets overlap");
         end
      end
   end

   logic [NREG-1:0][DATA_W-1:0] regs_q;

   padcfg_regfile #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .NREG   (NREG),
      .OFS    (OFS)
   ) regfile_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .regs_q (regs_q)
   );

   for (genvar n = 0; n < NPIN; n++) begin : g_pin
      logic [DRV_BITS-1:0] slice;
      for (genvar k = 0; k < DRV_BITS; k++) begin : g_slice
         assign slice[k] = regs_q[IDX_DRV0 + k][n];
      end

      padcfg_pin_decode #(
         .DRV_BITS (DRV_BITS)
      ) dec_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .pen      (regs_q[IDX_PEN][n]),
         .pdir     (regs_q[IDX_PDIR][n]),
         .drv_bits (slice),
         .up       (pull_up_en[n]),
         .dn       (pull_dn_en[n]),
         .code     (drv_code[n*DRV_BITS +: DRV_BITS]),
         .ma       (drv_ma[n*MA_W +: MA_W])
      );
   end

   // R5: a pull-up appears only on pins whose direction register bit was set
   p_up_needs_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_up_en & ~regs_q[IDX_PDIR][NPIN-1:0]) == '0);
endmodule

// File: tb/padcfg_bank_tb_top.sv
module padcfg_bank_tb_top;
   localparam int NPIN = 32;
   localparam int DB   = 3;
   localparam int MW   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NPIN-1:0] pull_up_en, pull_dn_en;
   logic [NPIN*DB-1:0] drv_code;
   logic [NPIN*MW-1:0] drv_ma;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] m_dir, m_en;
   logic [31:0] m_drv [3];

   always #10 clk = ~clk;

   padcfg_bank dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pull_up_en(pull_up_en),
      .pull_dn_en(pull_dn_en), .drv_code(drv_code), .drv_ma(drv_ma)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
   endtask

   // checks every pin's outputs against the model (R5 R6 R7 R8 R9)
   task automatic pins_chk(input string tag);
      #1;
      for (int n = 0; n < NPIN; n++) begin
         logic eu, ed;
         logic [2:0] ec;
         logic [4:0] em;
         eu = m_en[n] & m_dir[n];
         ed = m_en[n] & ~m_dir[n];
         ec = {m_drv[2][n], m_drv[1][n], m_drv[0][n]};
         em = 5'((int'(ec) + 1) * 2);
         chk(pull_up_en[n] == eu, {"R5 ", tag}, 64'(pull_up_en[n]), 64'(eu));
         chk(pull_dn_en[n] == ed, {"R6 R7 ", tag}, 64'(pull_dn_en[n]), 64'(ed));
         chk(drv_code[n*DB +: DB] == ec, {"R8 ", tag}, 64'(drv_code[n*DB +: DB]), 64'(ec));
         chk(drv_ma[n*MW +: MW] == em, {"R9 ", tag}, 64'(drv_ma[n*MW +: MW]), 64'(em));
      end
   endtask

   task automatic regs_chk(input string tag);
      rd_chk(8'h34, m_dir, {"R2 ", tag});
      rd_chk(8'h38, m_en, {"R3 ", tag});
      rd_chk(8'h58, m_drv[0], {"R4 ", tag});
      rd_chk(8'h5C, m_drv[1], {"R4 ", tag});
      rd_chk(8'h60, m_drv[2], {"R4 ", tag});
   endtask

   function automatic bit mapped(int a);
      return a == 'h34 || a == 'h38 || a == 'h58 || a == 'h5C || a == 'h60;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] pats [6];
      pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hAAAA_AAAA;
      pats[3] = 32'h5555_5555; pats[4] = 32'h8000_0001; pats[5] = 32'h0F0F_33C3;
      m_dir = '0; m_en = '0; m_drv[0] = '0; m_drv[1] = '0; m_drv[2] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      pins_chk("R1 reset");
      regs_chk("R1 reset");

      // R2 R3 R5 R6 R7: pull patterns, including enable-off with any direction
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++) begin
            wr(8'h34, pats[i]); m_dir = pats[i];
            pins_chk("dir write");
            wr(8'h38, pats[j]); m_en = pats[j];
            pins_chk("en write R11");
            regs_chk("pull");
         end

      // R8 R9: uniform code sweep 0..7
      for (int c = 0; c < 8; c++) begin
         for (int k = 0; k < 3; k++) begin
            m_drv[k] = ((c >> k) & 1) != 0 ? 32'hFFFF_FFFF : 32'h0;
            wr(8'(8'h58 + 4 * k), m_drv[k]);
         end
         pins_chk("uniform code");
         regs_chk("R4 uniform");
      end

      // R4 R8: distinct code per pin, pin n gets (n*3+1) mod 8
      for (int k = 0; k < 3; k++) begin
         m_drv[k] = '0;
         for (int n = 0; n < NPIN; n++) m_drv[k][n] = (((n * 3 + 1) % 8) >> k) & 1;
         wr(8'(8'h58 + 4 * k), m_drv[k]);
      end
      pins_chk("per-pin code");
      regs_chk("per-pin code");

      // R10: every unmapped offset reads zero
      for (int a = 0; a < 256; a++)
         if (!mapped(a)) rd_chk(8'(a), 32'h0, "R10 unmapped read");

      // R10: writes to unmapped or misaligned offsets change nothing
      wr(8'h30, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF); wr(8'h35, 32'hFFFF_FFFF);
      wr(8'h54, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF); wr(8'h59, 32'hFFFF_FFFF);
      wr(8'hB4, 32'hFFFF_FFFF);
      pins_chk("R10 unmapped write");
      regs_chk("R10 unmapped write");

      // R1: reset mid-run clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      m_dir = '0; m_en = '0; m_drv[0] = '0; m_drv[1] = '0; m_drv[2] = '0;
      pins_chk("R1 re-reset");
      regs_chk("R1 re-reset");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule